// File: doc/BRIEF.md
# Buffered Timer Time Base

This block is the time base of a general-purpose timer. A free-running up-counter advances once per prescaled tick and wraps to zero after it reaches the active top value. A repetition counter then turns every few wraps into one update event. The division ratio, the top value and the repetition count are written into staging registers. They take effect in the working copies only when an update event occurs, so software can retune a running timer without producing a short or torn period.

Update events come from two sources: counter wraps, after the repetition count is used up, and a software strobe. The strobe also restarts the counter and the prescaler from zero. A disable bit blocks both sources. A request-select bit lets a strobe reload the working copies without raising the sticky flag. The flag drives an interrupt request through an enable input. Software clears the flag by writing a one to it.

Top module: `tbu_timebase`

## Requirements
- R1: After reset the counter, the flag and the interrupt request are 0. The staged and working division values are 0, the staged and working top values are all ones, and the repetition values are 0.
- R2: With working division value P and top T, and with no repetition, the counter steps through 0..T and wraps to 0. An update event occurs every (P+1)*(T+1) clock cycles.
- R3: A value written at address 0 (staged division) is readable there at once. The working division at address 5 keeps its old value until the next update event.
- R4: With a repetition value R, an update event occurs once every R+1 wraps. Address 2 holds the staged R and address 7 reads the running repetition count. A new R takes effect after the next update event.
- R5: Address 1 holds the staged top value and address 6 reads the working top value. With preload enable at 1, a write reaches the working top only at the next update event. With preload enable at 0, the write reaches it one cycle later.
- R6: While update disable is 1, neither wraps nor the strobe produce an update pulse, and the working copies are not reloaded.
- R7: A strobe with update disable at 0 produces an update. The update pulse output is high in the cycle after the clock edge that takes an update event. At that edge the counter and the prescaler restart from 0 and the working copies load the staged values. With working division P, the counter first reads 1 after P+1 more edges.
- R8: When request select is 1, a strobe update leaves the flag unchanged. When it is 0, a strobe update sets the flag, and so does every wrap update. The flag only rises in a cycle that carries an update pulse.
- R9: The counter moves on the second rising edge after counter enable goes high. It takes exactly one more step at the first edge after enable goes low, and then holds.
- R10: The flag is sticky. Writing data bit 0 = 1 to address 4 clears it; bit 0 of address 4 reads the flag. If a set and a clear fall in the same cycle, the set wins.
- R11: The interrupt request equals the flag AND the interrupt enable input.
- R12: A wrap update and a strobe in the same cycle give a single update pulse. In that case the request-select bit alone decides whether the flag is set.
- R13: Address 3 reads the counter, and a write there loads it. A strobe in the same cycle takes priority over that write. Read data is zero-extended on the upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cen_i | input | 1 | Counter enable |
| arpe_i | input | 1 | Top-value preload enable |
| udis_i | input | 1 | Update disable |
| urs_i | input | 1 | Request select: strobe updates do not set the flag |
| ug_i | input | 1 | Software update strobe, one cycle |
| uie_i | input | 1 | Interrupt enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | CNT_W | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | CNT_W | Combinational read data |
| cnt_o | output | CNT_W | Counter value |
| upd_o | output | 1 | Update pulse |
| flag_o | output | 1 | Sticky update flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The collision to watch is a counter wrap update and a software strobe arriving on the same clock edge. A second collision is a flag set meeting a write-one clear. The bench runs the prescaler at ratio 1 and a top of 3, polls the counter until it reads the top value, and fires the strobe with request select high on exactly that edge. It then requires one single-cycle update pulse, a counter at 0 and the flag still low, and it requires the next natural wrap to set the flag. It also drives a flag-setting strobe together with a clear write and expects the flag to stay set.

// File: rtl/tbu_pkg.sv
package tbu_pkg;

   // Register address map of the time base
   typedef enum logic [2:0] {
      A_PSC     = 3'd0,
      A_ARR     = 3'd1,
      A_REP     = 3'd2,
      A_CNT     = 3'd3,
      A_STAT    = 3'd4,
      A_PSC_ACT = 3'd5,
      A_ARR_ACT = 3'd6,
      A_REP_ACT = 3'd7
   } tbu_addr_e;

endpackage

// File: rtl/tbu_prescaler.sv
module tbu_prescaler #(
   parameter int PSC_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             clr_i,
   input  logic [PSC_W-1:0] div_i,
   output logic             tick_o
);

   logic [PSC_W-1:0] pcnt_q;

   assign tick_o = run_i && (pcnt_q == div_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pcnt_q <= '0;
      end else if (clr_i) begin
         pcnt_q <= '0;
      end else if (run_i) begin
         pcnt_q <= tick_o ? '0 : pcnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/tbu_counter.sv
module tbu_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             clr_i,
   input  logic             ld_i,
   input  logic [CNT_W-1:0] ld_val_i,
   input  logic [CNT_W-1:0] top_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);

   logic [CNT_W-1:0] cnt_q;

   assign wrap_o = tick_i && (cnt_q == top_i);
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (ld_i) begin
         cnt_q <= ld_val_i;
      end else if (tick_i) begin
         cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/tbu_repeat.sv
module tbu_repeat #(
   parameter int REP_W   = 8,
   parameter bit HAS_REP = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wrap_i,
   input  logic             reload_i,
   input  logic [REP_W-1:0] rep_i,
   output logic             zero_o,
   output logic [REP_W-1:0] rep_cnt_o
);

   if (HAS_REP) begin : g_rep
      logic [REP_W-1:0] rcnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            rcnt_q <= '0;
         end else if (reload_i) begin
            rcnt_q <= rep_i;
         end else if (wrap_i && (rcnt_q != '0)) begin
            rcnt_q <= rcnt_q - 1'b1;
         end
      end

      assign zero_o    = (rcnt_q == '0);
      assign rep_cnt_o = rcnt_q;
   end else begin : g_norep
      assign zero_o    = 1'b1;
      assign rep_cnt_o = '0;
   end

endmodule

// File: rtl/tbu_timebase.sv
module tbu_timebase
   import tbu_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int PSC_W   = 16,
   parameter int REP_W   = 8,
   parameter bit HAS_REP = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cen_i,
   input  logic             arpe_i,
   input  logic             udis_i,
   input  logic             urs_i,
   input  logic             ug_i,
   input  logic             uie_i,
   input  logic             wr_en_i,
   input  logic [2:0]       wr_addr_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic [2:0]       rd_addr_i,
   output logic [CNT_W-1:0] rd_data_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             upd_o,
   output logic             flag_o,
   output logic             irq_o
);

   localparam logic [CNT_W-1:0] TOP_RST = '1;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("tbu_timebase: CNT_W must lie in 2..32");
   end
   if (PSC_W < 1 || PSC_W > CNT_W) begin : g_bad_psc
      $error("tbu_timebase: PSC_W must lie in 1..CNT_W");
   end
   if (REP_W < 1 || REP_W > CNT_W) begin : g_bad_rep
      $error("tbu_timebase: REP_W must lie in 1..CNT_W");
   end

   tbu_addr_e        wa, ra;
   logic             cen_q, upd_q, flag_q;
   logic [PSC_W-1:0] psc_pre, psc_act;
   logic [CNT_W-1:0] arr_pre, arr_act;
   logic [REP_W-1:0] rep_pre, rep_cnt;
   logic             tick, wrap, rep_zero;
   logic             sw_upd, hw_upd, uev, flag_set, flag_clr;
   logic             wr_psc, wr_arr, wr_rep, wr_cnt;

   assign wa = tbu_addr_e'(wr_addr_i);
   assign ra = tbu_addr_e'(rd_addr_i);

   assign wr_psc   = wr_en_i && (wa == A_PSC);
   assign wr_arr   = wr_en_i && (wa == A_ARR);
   assign wr_rep   = wr_en_i && (wa == A_REP);
   assign wr_cnt   = wr_en_i && (wa == A_CNT);
   assign flag_clr = wr_en_i && (wa == A_STAT) && wr_data_i[0];

   // Update sources merge into one event; the strobe decides the flag
   assign sw_upd   = ug_i && !udis_i;
   assign hw_upd   = wrap && rep_zero && !udis_i;
   assign uev      = sw_upd || hw_upd;
   assign flag_set = sw_upd ? !urs_i : hw_upd;

   tbu_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (cen_q),
      .clr_i  (sw_upd),
      .div_i  (psc_act),
      .tick_o (tick)
   );

   tbu_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .clr_i    (sw_upd),
      .ld_i     (wr_cnt),
      .ld_val_i (wr_data_i),
      .top_i    (arr_act),
      .cnt_o    (cnt_o),
      .wrap_o   (wrap)
   );

   tbu_repeat #(.REP_W(REP_W), .HAS_REP(HAS_REP)) u_rep (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wrap_i    (wrap),
      .reload_i  (uev),
      .rep_i     (rep_pre),
      .zero_o    (rep_zero),
      .rep_cnt_o (rep_cnt)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cen_q   <= 1'b0;
         upd_q   <= 1'b0;
         flag_q  <= 1'b0;
         psc_pre <= '0;
         psc_act <= '0;
         arr_pre <= TOP_RST;
         arr_act <= TOP_RST;
         rep_pre <= '0;
      end else begin
         cen_q <= cen_i;
         upd_q <= uev;

         if (wr_psc) psc_pre <= wr_data_i[PSC_W-1:0];
         if (wr_arr) arr_pre <= wr_data_i;
         if (wr_rep) rep_pre <= wr_data_i[REP_W-1:0];

         if (uev) begin
            psc_act <= psc_pre;
            arr_act <= arr_pre;
         end
         if (wr_arr && !arpe_i) begin
            arr_act <= wr_data_i;
         end

         if (flag_set) begin
            flag_q <= 1'b1;
         end else if (flag_clr) begin
            flag_q <= 1'b0;
         end
      end
   end

   always_comb begin
      case (ra)
         A_PSC:     rd_data_o = CNT_W'(psc_pre);
         A_ARR:     rd_data_o = arr_pre;
         A_REP:     rd_data_o = CNT_W'(rep_pre);
         A_CNT:     rd_data_o = cnt_o;
         A_STAT:    rd_data_o = CNT_W'(flag_q);
         A_PSC_ACT: rd_data_o = CNT_W'(psc_act);
         A_ARR_ACT: rd_data_o = arr_act;
         A_REP_ACT: rd_data_o = CNT_W'(rep_cnt);
         default:   rd_data_o = '0;
      endcase
   end

   assign upd_o  = upd_q;
   assign flag_o = flag_q;
   assign irq_o  = flag_q && uie_i;

endmodule

// File: rtl/tbu_timebase_chk.sv
module tbu_timebase_chk
   import tbu_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PSC_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             cen_q,
   input logic             ug_i,
   input logic             udis_i,
   input logic             wr_en_i,
   input logic [2:0]       wr_addr_i,
   input logic             wr_bit0,
   input logic [PSC_W-1:0] psc_act,
   input logic [CNT_W-1:0] cnt_o,
   input logic             upd_o,
   input logic             flag_o
);

   // R8: flag can only rise together with an update pulse
   p_flag_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o) |-> upd_o);

   // R6: no update pulse follows a cycle with update disable set
   p_udis_silent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_o |-> !$past(udis_i));

   // R7: an accepted strobe restarts the counter
   p_ug_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ug_i && !udis_i) |=> (cnt_o == '0));

   // R3: working division changes only in an update cycle
   p_psc_buffered_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(psc_act) |-> upd_o);

   // R9: counter holds while the delayed enable is low
   p_hold_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cen_q && !ug_i && !(wr_en_i && wr_addr_i == A_CNT)) |=> $stable(cnt_o));

   // R10: flag stays set until a write-one clear
   p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o && !(wr_en_i && wr_addr_i == A_STAT && wr_bit0)) |=> flag_o);

endmodule

bind tbu_timebase tbu_timebase_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .cen_q     (cen_q),
   .ug_i      (ug_i),
   .udis_i    (udis_i),
   .wr_en_i   (wr_en_i),
   .wr_addr_i (wr_addr_i),
   .wr_bit0   (wr_data_i[0]),
   .psc_act   (psc_act),
   .cnt_o     (cnt_o),
   .upd_o     (upd_o),
   .flag_o    (flag_o)
);

// File: tb/tbu_timebase_bench.sv
module tbu_timebase_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cen = 0, arpe = 0, udis = 0, urs = 0, ug = 0, uie = 0;
   logic        wr_en = 0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data, cnt;
   logic        upd, flag, irq;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   tbu_timebase u_tbu_timebase (
      .clk_i (clk), .rst_ni (rst_n), .cen_i (cen), .arpe_i (arpe),
      .udis_i (udis), .urs_i (urs), .ug_i (ug), .uie_i (uie),
      .wr_en_i (wr_en), .wr_addr_i (wr_addr), .wr_data_i (wr_data),
      .rd_addr_i (rd_addr), .rd_data_o (rd_data), .cnt_o (cnt),
      .upd_o (upd), .flag_o (flag), .irq_o (irq)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic ug_pulse(input logic sel);
      urs = sel; ug = 1'b1;
      @(negedge clk);
      ug = 1'b0;
   endtask

   // Cycles until the next update pulse is seen
   task automatic wait_upd(output int n, output int mx);
      n = 0; mx = 0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         n++;
         if (int'(cnt) > mx) mx = int'(cnt);
         if (upd) break;
      end
   endtask

   task automatic t_reset();
      logic [15:0] v;
      chk("R1", "counter", cnt, 0);
      chk("R1", "flag", flag, 0);
      chk("R1", "irq", irq, 0);
      rd(3'd6, v); chk("R1", "working top", v, 16'hFFFF);
      rd(3'd5, v); chk("R1", "working division", v, 0);
      @(negedge clk);
   endtask

   task automatic t_enable();
      logic [15:0] a;
      cen = 1'b1;
      @(negedge clk); chk("R9", "first edge after enable", cnt, 0);
      @(negedge clk); chk("R9", "second edge after enable", cnt, 1);
      @(negedge clk); chk("R9", "third edge", cnt, 2);
      cen = 1'b0;
      @(negedge clk); chk("R9", "one step after disable", cnt, 3);
      a = cnt;
      @(negedge clk); chk("R9", "hold 1", cnt, a);
      @(negedge clk); chk("R9", "hold 2", cnt, a);
   endtask

   task automatic t_period();
      int p, mx;
      wr(3'd0, 16'd1); wr(3'd1, 16'd3); wr(3'd2, 16'd0);
      ug_pulse(1'b1);
      cen = 1'b1;
      wait_upd(p, mx);
      wait_upd(p, mx);
      chk("R2", "period psc1 top3", p, 8);
      chk("R2", "highest count", mx, 3);
   endtask

   task automatic t_repeat();
      int p, mx;
      logic [15:0] v;
      wr(3'd2, 16'd2);
      wait_upd(p, mx);
      wait_upd(p, mx);
      chk("R4", "period with repetition 2", p, 24);
      rd(3'd2, v); chk("R4", "staged repetition", v, 2);
      @(negedge clk);
   endtask

   task automatic t_psc_buffer();
      int p, mx;
      logic [15:0] v;
      wr(3'd0, 16'd3);
      rd(3'd0, v); chk("R3", "staged division", v, 3);
      rd(3'd5, v); chk("R3", "working division before update", v, 1);
      wait_upd(p, mx);
      rd(3'd5, v); chk("R3", "working division after update", v, 3);
      wait_upd(p, mx);
      chk("R3", "period with new division", p, 48);
      @(negedge clk);
      wr(3'd0, 16'd0); wr(3'd2, 16'd0);
      ug_pulse(1'b1);
   endtask

   task automatic t_arpe();
      int p, mx;
      logic [15:0] v;
      arpe = 1'b1;
      wr(3'd1, 16'd5);
      rd(3'd6, v); chk("R5", "preloaded top held", v, 3);
      wait_upd(p, mx);
      rd(3'd6, v); chk("R5", "preloaded top at update", v, 5);
      @(negedge clk);
      cen = 1'b0;
      ug_pulse(1'b1);
      arpe = 1'b0;
      wr(3'd1, 16'd2);
      rd(3'd6, v); chk("R5", "direct top write", v, 2);
      @(negedge clk);
      cen = 1'b1;
   endtask

   task automatic t_udis();
      int seen, p, mx;
      logic [15:0] v;
      udis = 1'b1;
      seen = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (upd) seen++;
      end
      chk("R6", "pulses while disabled", seen, 0);
      wr(3'd0, 16'd5);
      ug_pulse(1'b0);
      chk("R6", "strobe blocked", upd, 0);
      rd(3'd5, v); chk("R6", "working division unchanged", v, 0);
      @(negedge clk);
      wr(3'd0, 16'd0);
      udis = 1'b0;
      wait_upd(p, mx);
      chk("R6", "updates resume within period", (p <= 3), 1);
   endtask

   task automatic t_ug();
      int p, mx;
      wr(3'd0, 16'd3);
      wr(3'd1, 16'd100);
      ug_pulse(1'b1);
      for (int i = 0; i < 37; i++) @(negedge clk);
      ug_pulse(1'b1);
      chk("R7", "pulse after strobe", upd, 1);
      chk("R7", "counter restarted", cnt, 0);
      @(negedge clk); @(negedge clk); @(negedge clk);
      chk("R7", "prescaler restarted, still 0", cnt, 0);
      @(negedge clk);
      chk("R7", "first step after P+1 edges", cnt, 1);
      wr(3'd3, 16'd50);
      chk("R13", "counter load", cnt, 50);
      p = 0; mx = 0;
   endtask

   task automatic t_flag();
      logic [15:0] v;
      cen = 1'b0;
      @(negedge clk);
      wr(3'd4, 16'd1);
      ug_pulse(1'b1);
      chk("R8", "silent strobe pulses", upd, 1);
      chk("R8", "silent strobe leaves flag", flag, 0);
      ug_pulse(1'b0);
      chk("R8", "strobe sets flag", flag, 1);
      uie = 1'b0;
      #1 chk("R11", "irq masked", irq, 0);
      uie = 1'b1;
      #1 chk("R11", "irq enabled", irq, 1);
      @(negedge clk);
      rd(3'd4, v); chk("R10", "status reads flag", v, 1);
      @(negedge clk);
      wr(3'd4, 16'd1);
      chk("R10", "write-one clears", flag, 0);
      chk("R11", "irq follows flag", irq, 0);
      wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'd1; urs = 1'b0; ug = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; ug = 1'b0;
      chk("R10", "set wins over clear", flag, 1);
      wr(3'd4, 16'd1);
      uie = 1'b0;
   endtask

   task automatic t_collide();
      int p, mx;
      wr(3'd0, 16'd0);
      wr(3'd1, 16'd3);
      ug_pulse(1'b1);
      wr(3'd4, 16'd1);
      cen = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (cnt == 16'd3) break;
      end
      chk("R12", "reached top", cnt, 3);
      ug_pulse(1'b1);
      chk("R12", "one pulse", upd, 1);
      chk("R12", "strobe keeps flag low", flag, 0);
      chk("R12", "counter at 0", cnt, 0);
      @(negedge clk);
      chk("R12", "pulse is single", upd, 0);
      wait_upd(p, mx);
      chk("R12", "next wrap period", p, 3);
      chk("R8", "wrap update sets flag", flag, 1);
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_period();
      t_repeat();
      t_psc_buffer();
      t_arpe();
      t_udis();
      t_ug();
      t_flag();
      t_collide();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule